// File: doc/BRIEF.md
# Lane Alignment Preamble Generator

This block builds the training preamble that a converter serial link transmitter sends on a lane once comma synchronization is finished. A single start pulse launches the preamble. The preamble is four back-to-back multiframes. Each multiframe is `frame_bytes_i * mf_frames_i` bytes long.

Each multiframe opens and closes with fixed control characters. The second multiframe also carries a configuration marker, followed by a 14-byte link configuration record supplied by the caller. Every other position carries a byte-position ramp, which gives a receiver predictable content to compare against.

The lane runs four bytes per clock. A per-byte control flag marks which bytes are control characters. A one-cycle completion pulse rides on the word that carries the final closing marker, so the surrounding link controller can switch to user data on the next word. The multiframe length and the configuration record are captured when the start pulse is accepted. Their inputs may change freely while the preamble is being sent.

Top module: `ilas_align_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `lane_valid_o`, `seq_done_o`, `lane_k_o` and `lane_data_o` are all zero.
- R2: After a start pulse is accepted at a rising edge, `lane_valid_o` is still low after that edge. It goes high after the next edge and then stays high for exactly F*K consecutive words (4*F*K bytes over four multiframes). It is low again on the cycle after the last word.
- R3: The byte at position 0 of every multiframe is 0x1C with its control flag set.
- R4: The byte at position F*K-1 of every multiframe is 0x7C with its control flag set.
- R5: In the second multiframe (index 1), the byte at position 1 is 0x9C with its control flag set.
- R6: In the second multiframe, positions 2 to 15 carry configuration bytes 0 to 13 in order, with the control flag clear. Configuration byte j is `cfg_rec_i[8j+7:8j]`, sampled when the start is accepted; later changes to `cfg_rec_i` do not affect the sequence.
- R7: Every other position p carries the value p mod 256 with the control flag clear. Within a word, byte lane i (`lane_data_o[8i+7:8i]`, flag `lane_k_o[i]`) holds the byte sent i positions after lane 0.
- R8: `seq_done_o` is high for exactly one cycle, on the word whose lane 3 holds the last closing marker of the fourth multiframe.
- R9: A start pulse that arrives while a sequence is running is ignored. The running sequence finishes unchanged, and no second sequence follows it.
- R10: A start pulse is ignored, and no word is produced, when F*K is below 20 or is not a multiple of 4. A product of 20 is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; taken only when idle and the geometry is legal |
| frame_bytes_i | input | 8 | Octets per frame (F) |
| mf_frames_i | input | 6 | Frames per multiframe (K) |
| cfg_rec_i | input | 112 | Link configuration record, byte 0 in the low bits |
| lane_data_o | output | 32 | Lane word, earliest byte in bits 7:0 |
| lane_k_o | output | 4 | Control-character flag per byte lane |
| lane_valid_o | output | 1 | Word is part of the preamble |
| seq_done_o | output | 1 | One-cycle pulse with the final word |

## Verification
The hardest situations to create from the ports are those where the record and the geometry inputs change, and a second start arrives, in the middle of a running preamble. The capture-at-start behaviour only shows if the later words still carry the old record and the old length. The stimulus therefore pulses start again partway through selected sequences, and at the same time inverts the record and changes F. It then checks every remaining byte against the values taken at launch, and confirms that the lane stays quiet afterwards.

The smallest legal multiframe of 20 bytes is driven on purpose. At that size the end of the record, three ramp bytes and the closing marker sit tightly together. A 512-byte multiframe is also driven, to reach the wrap of the ramp past 255.

// File: rtl/ilas_pkg.sv
`timescale 1ns/1ps
package ilas_pkg;

    localparam logic [7:0] CODE_MF_START = 8'h1C;
    localparam logic [7:0] CODE_MF_END   = 8'h7C;
    localparam logic [7:0] CODE_CFG_MARK = 8'h9C;

    typedef struct packed {
        logic       is_k;
        logic [7:0] val;
    } lane_byte_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    function automatic lane_byte_t mk_ctrl(input logic [7:0] code);
        lane_byte_t b;
        b.is_k = 1'b1;
        b.val  = code;
        return b;
    endfunction

    function automatic lane_byte_t mk_data(input logic [7:0] v);
        lane_byte_t b;
        b.is_k = 1'b0;
        b.val  = v;
        return b;
    endfunction

    function automatic logic is_marker(input logic [7:0] v);
        return (v == CODE_MF_START) || (v == CODE_MF_END) || (v == CODE_CFG_MARK);
    endfunction

endpackage

// File: rtl/ilas_seq_ctrl.sv
`timescale 1ns/1ps
module ilas_seq_ctrl
    import ilas_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int F_W       = 8,
    parameter int K_W       = 6,
    parameter int MF_NUM    = 4,
    parameter int CFG_BYTES = 14,
    localparam int LEN_W    = F_W + K_W,
    localparam int MF_W     = (MF_NUM > 1) ? $clog2(MF_NUM) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic [F_W-1:0]                frame_bytes_i,
    input  logic [K_W-1:0]                mf_frames_i,
    input  logic [CFG_BYTES-1:0][7:0]     cfg_i,
    output logic                          run_o,
    output logic                          last_o,
    output logic [LEN_W-1:0]              pos_o,
    output logic [MF_W-1:0]               mf_o,
    output logic [LEN_W-1:0]              len_o,
    output logic [CFG_BYTES-1:0][7:0]     cfg_q_o
);

    // start marker + config marker + record + end marker, rounded up to whole words
    localparam int MIN_LEN = ((CFG_BYTES + 3 + LANES - 1) / LANES) * LANES;

    seq_state_e               st_q;
    logic [LEN_W-1:0]         pos_q;
    logic [LEN_W-1:0]         len_q;
    logic [MF_W-1:0]          mf_q;
    logic [CFG_BYTES-1:0][7:0] cfg_q;
    logic [LEN_W-1:0]         geom_len;
    logic                     geom_ok;
    logic                     mf_end;
    logic                     last_word;

    assign geom_len  = LEN_W'(frame_bytes_i) * LEN_W'(mf_frames_i);
    assign geom_ok   = (geom_len >= LEN_W'(MIN_LEN)) &&
                       ((geom_len % LEN_W'(LANES)) == '0);
    assign mf_end    = (pos_q == len_q - LEN_W'(LANES));
    assign last_word = (st_q == ST_RUN) && mf_end && (mf_q == MF_W'(MF_NUM - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
            len_q <= '0;
            mf_q  <= '0;
            cfg_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i && geom_ok) begin
                        st_q  <= ST_RUN;
                        pos_q <= '0;
                        mf_q  <= '0;
                        len_q <= geom_len;
                        cfg_q <= cfg_i;
                    end
                end
                ST_RUN: begin
                    if (mf_end) begin
                        pos_q <= '0;
                        if (last_word) begin
                            st_q <= ST_IDLE;
                            mf_q <= '0;
                        end else begin
                            mf_q <= mf_q + MF_W'(1);
                        end
                    end else begin
                        pos_q <= pos_q + LEN_W'(LANES);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign run_o   = (st_q == ST_RUN);
    assign last_o  = last_word;
    assign pos_o   = pos_q;
    assign mf_o    = mf_q;
    assign len_o   = len_q;
    assign cfg_q_o = cfg_q;

    // R9: a running sequence is never cut short, whatever start does
    a_r9_run_persists: assert property (@(posedge clk) disable iff (rst)
        (run_o && !last_o) |=> run_o);

    // R2: inside a multiframe the position advances one word per cycle
    a_r2_pos_step: assert property (@(posedge clk) disable iff (rst)
        (run_o && !mf_end) |=> (pos_q == $past(pos_q) + LEN_W'(LANES)));

    // R10: only a legal geometry can be running
    a_r10_geom_legal: assert property (@(posedge clk) disable iff (rst)
        run_o |-> ((len_q >= LEN_W'(MIN_LEN)) && ((len_q % LEN_W'(LANES)) == '0)));

endmodule

// File: rtl/ilas_lane_byte.sv
`timescale 1ns/1ps
module ilas_lane_byte
    import ilas_pkg::*;
#(
    parameter int LANE_IDX  = 0,
    parameter int LEN_W     = 14,
    parameter int MF_W      = 2,
    parameter int CFG_BYTES = 14
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LEN_W-1:0]          pos_i,
    input  logic [MF_W-1:0]           mf_i,
    input  logic [LEN_W-1:0]          len_i,
    input  logic [CFG_BYTES-1:0][7:0] cfg_i,
    output lane_byte_t                byte_o
);

    localparam int CIDX_W  = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1;
    localparam int CFG_LO  = 2;
    localparam int CFG_HI  = CFG_LO + CFG_BYTES;

    logic [LEN_W-1:0]  p;
    logic [CIDX_W-1:0] cfg_idx;
    logic              in_cfg_mf;

    assign p         = pos_i + LEN_W'(LANE_IDX);
    assign cfg_idx   = CIDX_W'(p - LEN_W'(CFG_LO));
    assign in_cfg_mf = (mf_i == MF_W'(1));

    always_comb begin
        byte_o = mk_data(p[7:0]);
        if (p == '0) begin
            byte_o = mk_ctrl(CODE_MF_START);
        end else if (p == len_i - LEN_W'(1)) begin
            byte_o = mk_ctrl(CODE_MF_END);
        end else if (in_cfg_mf && p == LEN_W'(1)) begin
            byte_o = mk_ctrl(CODE_CFG_MARK);
        end else if (in_cfg_mf && p >= LEN_W'(CFG_LO) && p < LEN_W'(CFG_HI)) begin
            byte_o = mk_data(cfg_i[cfg_idx]);
        end
    end

    // R5: a flagged byte is always one of the three marker codes
    a_r5_k_code_legal: assert property (@(posedge clk) disable iff (rst)
        byte_o.is_k |-> is_marker(byte_o.val));

endmodule

// File: rtl/ilas_word_reg.sv
`timescale 1ns/1ps
module ilas_word_reg
    import ilas_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run_i,
    input  logic                    last_i,
    input  lane_byte_t [LANES-1:0]  bytes_i,
    output logic [LANES*8-1:0]      data_o,
    output logic [LANES-1:0]        k_o,
    output logic                    valid_o,
    output logic                    done_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            k_o     <= '0;
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            valid_o <= run_i;
            done_o  <= last_i;
            for (int i = 0; i < LANES; i++) begin
                data_o[8*i +: 8] <= run_i ? bytes_i[i].val  : 8'h00;
                k_o[i]           <= run_i ? bytes_i[i].is_k : 1'b0;
            end
        end
    end

    // R8: completion rides on a valid word whose top lane is the end marker
    a_r8_done_on_end_marker: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (valid_o && k_o[LANES-1] && data_o[LANES*8-1 -: 8] == CODE_MF_END));

    // R8: the lane goes quiet right after completion
    a_r8_done_then_quiet: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !valid_o);

    // R3: the first word of a preamble opens with the start marker
    a_r3_first_word_opens: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> (k_o[0] && data_o[7:0] == CODE_MF_START));

    // R1: idle lanes carry no flags
    a_r1_idle_clean: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (k_o == '0 && !done_o));

endmodule

// File: rtl/ilas_align_gen.sv
`timescale 1ns/1ps
module ilas_align_gen
    import ilas_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int F_W       = 8,
    parameter int K_W       = 6,
    parameter int MF_NUM    = 4,
    parameter int CFG_BYTES = 14
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [F_W-1:0]         frame_bytes_i,
    input  logic [K_W-1:0]         mf_frames_i,
    input  logic [CFG_BYTES*8-1:0] cfg_rec_i,
    output logic [LANES*8-1:0]     lane_data_o,
    output logic [LANES-1:0]       lane_k_o,
    output logic                   lane_valid_o,
    output logic                   seq_done_o
);

    localparam int LEN_W = F_W + K_W;
    localparam int MF_W  = (MF_NUM > 1) ? $clog2(MF_NUM) : 1;

    logic [CFG_BYTES-1:0][7:0] cfg_arr;
    logic [CFG_BYTES-1:0][7:0] cfg_q;
    logic                      run;
    logic                      last;
    logic [LEN_W-1:0]          pos;
    logic [LEN_W-1:0]          len;
    logic [MF_W-1:0]           mf;
    lane_byte_t [LANES-1:0]    lane_bytes;

    assign cfg_arr = cfg_rec_i;

    ilas_seq_ctrl #(
        .LANES     (LANES),
        .F_W       (F_W),
        .K_W       (K_W),
        .MF_NUM    (MF_NUM),
        .CFG_BYTES (CFG_BYTES)
    ) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .frame_bytes_i (frame_bytes_i),
        .mf_frames_i   (mf_frames_i),
        .cfg_i         (cfg_arr),
        .run_o         (run),
        .last_o        (last),
        .pos_o         (pos),
        .mf_o          (mf),
        .len_o         (len),
        .cfg_q_o       (cfg_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ilas_lane_byte #(
            .LANE_IDX  (g),
            .LEN_W     (LEN_W),
            .MF_W      (MF_W),
            .CFG_BYTES (CFG_BYTES)
        ) byte_i (
            .clk    (clk),
            .rst    (rst),
            .pos_i  (pos),
            .mf_i   (mf),
            .len_i  (len),
            .cfg_i  (cfg_q),
            .byte_o (lane_bytes[g])
        );
    end

    ilas_word_reg #(
        .LANES (LANES)
    ) out_i (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .last_i  (last),
        .bytes_i (lane_bytes),
        .data_o  (lane_data_o),
        .k_o     (lane_k_o),
        .valid_o (lane_valid_o),
        .done_o  (seq_done_o)
    );

endmodule

// File: tb/ilas_align_gen_tb_top.sv
`timescale 1ns/1ps
module ilas_align_gen_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [7:0]   frame_bytes;
    logic [5:0]   mf_frames;
    logic [111:0] cfg;
    logic [31:0]  lane_data;
    logic [3:0]   lane_k;
    logic         lane_valid;
    logic         seq_done;

    int checks   = 0;
    int errors   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ilas_align_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .frame_bytes_i (frame_bytes),
        .mf_frames_i   (mf_frames),
        .cfg_rec_i     (cfg),
        .lane_data_o   (lane_data),
        .lane_k_o      (lane_k),
        .lane_valid_o  (lane_valid),
        .seq_done_o    (seq_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected {flag, byte} for position p of multiframe m
    function automatic logic [8:0] exp_byte(input int m, input int p, input int len,
                                            input logic [111:0] c);
        if (p == 0)                       return {1'b1, 8'h1C};
        if (p == len - 1)                 return {1'b1, 8'h7C};
        if (m == 1 && p == 1)             return {1'b1, 8'h9C};
        if (m == 1 && p >= 2 && p < 16)   return {1'b0, c[(p-2)*8 +: 8]};
        return {1'b0, 8'(p)};
    endfunction

    function automatic string req_of(input int m, input int p, input int len);
        if (p == 0)                       return "R3";
        if (p == len - 1)                 return "R4";
        if (m == 1 && p == 1)             return "R5";
        if (m == 1 && p >= 2 && p < 16)   return "R6";
        return "R7";
    endfunction

    // one full preamble; disturb re-pulses start and alters inputs mid-run (R9, R6)
    task automatic run_seq(input int f, input int kk, input logic [111:0] c, input bit disturb);
        int len;
        len = f * kk;
        @(negedge clk);
        frame_bytes = 8'(f);
        mf_frames   = 6'(kk);
        cfg         = c;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(lane_valid == 1'b0, "R2", "valid one edge after start", 64'(lane_valid), 64'd0);
        for (int w = 0; w < len; w++) begin
            @(negedge clk);
            if (disturb && w == 3) begin
                start       = 1'b1;
                cfg         = ~c;
                frame_bytes = 8'(f + 4);
            end else if (disturb && w == 4) begin
                start = 1'b0;
            end
            chk(lane_valid == 1'b1, "R2", "valid during preamble", 64'(lane_valid), 64'd1);
            chk(seq_done == (w == len - 1), "R8", "done pulse", 64'(seq_done),
                64'(w == len - 1));
            for (int i = 0; i < 4; i++) begin
                int bi, m, p;
                logic [8:0] e;
                bi = w * 4 + i;
                m  = bi / len;
                p  = bi % len;
                e  = exp_byte(m, p, len, c);
                chk({lane_k[i], lane_data[8*i +: 8]} == e, req_of(m, p, len),
                    $sformatf("mf %0d pos %0d lane %0d", m, p, i),
                    64'({lane_k[i], lane_data[8*i +: 8]}), 64'(e));
            end
        end
        start = 1'b0;
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            chk(lane_valid == 1'b0 && seq_done == 1'b0, disturb ? "R9" : "R2",
                "lane quiet after preamble", 64'({lane_valid, seq_done}), 64'd0);
        end
    endtask

    task automatic bad_geom(input int f, input int kk);
        @(negedge clk);
        frame_bytes = 8'(f);
        mf_frames   = 6'(kk);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            chk(lane_valid == 1'b0, "R10", $sformatf("start ignored F=%0d K=%0d", f, kk),
                64'(lane_valid), 64'd0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [127:0] t;
        int f, kk;
        void'($urandom(32'd20240611));
        rst         = 1'b1;
        start       = 1'b0;
        frame_bytes = 8'd2;
        mf_frames   = 6'd10;
        cfg         = '0;
        repeat (3) @(negedge clk);
        chk(lane_valid == 0 && seq_done == 0 && lane_k == 0 && lane_data == 0, "R1",
            "outputs in reset", 64'({lane_valid, seq_done, lane_k, lane_data}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(lane_valid == 0 && seq_done == 0 && lane_k == 0 && lane_data == 0, "R1",
            "outputs after reset", 64'({lane_valid, seq_done, lane_k, lane_data}), 64'd0);

        // smallest legal multiframe (R10 boundary)
        t = {$urandom(), $urandom(), $urandom(), $urandom()};
        run_seq(2, 10, t[111:0], 1'b0);
        // ramp wrap past 255 (R7)
        t = {$urandom(), $urandom(), $urandom(), $urandom()};
        run_seq(32, 16, t[111:0], 1'b0);
        // mid-run start and input changes (R9, R6)
        t = {$urandom(), $urandom(), $urandom(), $urandom()};
        run_seq(4, 6, t[111:0], 1'b1);

        // illegal geometries (R10)
        bad_geom(3, 3);
        bad_geom(4, 4);
        bad_geom(0, 8);
        bad_geom(5, 5);

        for (int n = 0; n < 6; n++) begin
            do begin
                f  = 1 + int'($urandom() % 16);
                kk = 1 + int'($urandom() % 32);
            end while ((f * kk) < 20 || ((f * kk) % 4) != 0);
            t = {$urandom(), $urandom(), $urandom(), $urandom()};
            run_seq(f, kk, t[111:0], n[0]);
        end

        finish_run();
    end

endmodule